// File: doc/BRIEF.md
# Indexed codec register window

This block is the host-facing register window of an audio codec. The host sees only two byte-wide ports. The control port holds a register pointer and three mode flags. The data port reads or writes whichever of 32 internal control bytes the pointer selects. A write takes effect on the clock edge where the strobe is high. A read is combinational from the port select.

Around that window the block also does the following:
- It guards the sample-format and interface-setup registers against writes unless mode changes are enabled.
- It holds the DAC muted while mode changes are enabled.
- It gates the playback and capture DMA requests using each channel's interrupt flag.
- It hides the control port behind a fixed busy value during start-up and while power-down is requested.

Top module: `regwin_top`

## Requirements
- R1: The control port byte is {bit7 busy (read-only, reads 0 when idle), bit6 mode-change enable, bit5 request-gate enable, bits 4..0 register pointer}. Written flag and pointer values read back unchanged, and writing 1 to bit7 has no effect.
- R2: After reset, a start-up phase of INIT_CYCLES clocks runs. During it the control port reads 0x80 and writes to both ports are ignored. Afterwards the control port reads 0x40.
- R3: While pwr_down is high the control port reads 0x80 and writes to it are ignored. When pwr_down is released, the flags and pointer read back as they were before.
- R4: The data port reads and writes the one of 32 registers selected by the effective pointer. Every register keeps its own value.
- R5: While legacy_mode is high, a written pointer bit 4 is stored as 0, bit 4 reads back as 0, and only registers 0 to 15 are reachable.
- R6: While mode-change enable is 0, data port writes to registers 8 and 28 leave them unchanged.
- R7: While mode-change enable is 0, a data port write to register 9 updates only bits 1 and 0 (playback and capture enable). Bits 7..2 keep their value.
- R8: dac_mute is high exactly while mode-change enable is set, and it is high after reset.
- R9: When the request-gate flag is 0, each DMA request output follows its input. When the flag is 1, each output is its input ANDed with the inverse of that channel's own interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_port | input | 1 | Port select: 0 control, 1 data |
| host_wr | input | 1 | Write strobe for the selected port |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Read byte of the selected port |
| legacy_mode | input | 1 | Restricts the pointer to 16 registers |
| pwr_down | input | 1 | Level-sensitive software power-down |
| play_drq_in | input | 1 | Raw playback DMA request |
| capt_drq_in | input | 1 | Raw capture DMA request |
| play_irq | input | 1 | Playback interrupt flag |
| capt_irq | input | 1 | Capture interrupt flag |
| play_drq_out | output | 1 | Gated playback DMA request |
| capt_drq_out | output | 1 | Gated capture DMA request |
| dac_mute | output | 1 | DAC mute |

## Verification
The hardest case to reach is a data write that is blocked. It can only be seen after the register has first been loaded with a known pattern while mode changes were enabled. After that, mode changes are disabled and the inverted pattern is written to registers 8, 9 and 28. Each register is read back with the protection still active, so the bench can tell which bits moved. The start-up lockout is reached the same way. A write is attempted in the first clocks after reset, and the target register is read once start-up ends.

// File: rtl/regwin_pkg.sv
package regwin_pkg;
    localparam int BYTE_W   = 8;
    localparam int IDX_W    = 5;
    localparam int NUM_REGS = 1 << IDX_W;

    localparam logic PORT_CTRL = 1'b0;
    localparam logic PORT_DATA = 1'b1;

    localparam logic [BYTE_W-1:0] BUSY_READ     = 8'h80;
    localparam logic [BYTE_W-1:0] CFG_FREE_MASK = 8'h03;

    localparam logic [IDX_W-1:0] FMT_A_IDX = 5'd8;
    localparam logic [IDX_W-1:0] FMT_B_IDX = 5'd28;
    localparam logic [IDX_W-1:0] CFG_IDX   = 5'd9;

    typedef struct packed {
        logic             mce;
        logic             trd;
        logic [IDX_W-1:0] idx;
    } win_flags_t;

    function automatic logic is_fmt_reg(input logic [IDX_W-1:0] i);
        return (i == FMT_A_IDX) || (i == FMT_B_IDX);
    endfunction

    function automatic logic is_cfg_reg(input logic [IDX_W-1:0] i);
        return i == CFG_IDX;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ctrl(input win_flags_t f,
                                                    input logic [IDX_W-1:0] shown);
        return {1'b0, f.mce, f.trd, shown};
    endfunction
endpackage

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
    import regwin_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_down,
    input  logic              legacy_mode,
    input  logic              idx_wr,
    input  logic [BYTE_W-1:0] wdata,
    output win_flags_t        flags,
    output logic              init_busy,
    output logic              locked,
    output logic [IDX_W-1:0]  eff_idx,
    output logic [BYTE_W-1:0] ctrl_rdata
);
    localparam int CNT_W = $clog2(INIT_CYCLES + 1);

    logic [CNT_W-1:0] init_cnt;

    always_ff @(posedge clk) begin
        if (rst)
            init_cnt <= CNT_W'(INIT_CYCLES);
        else if (init_cnt != '0)
            init_cnt <= init_cnt - 1'b1;
    end

    assign init_busy = (init_cnt != '0);
    assign locked    = init_busy | pwr_down;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags.mce <= 1'b1;
            flags.trd <= 1'b0;
            flags.idx <= '0;
        end else if (idx_wr && !locked) begin
            flags.mce <= wdata[6];
            flags.trd <= wdata[5];
            flags.idx <= {wdata[4] & ~legacy_mode, wdata[3:0]};
        end
    end

    always_comb begin
        eff_idx = flags.idx;
        if (legacy_mode)
            eff_idx[IDX_W-1] = 1'b0;
    end

    assign ctrl_rdata = locked ? BUSY_READ : pack_ctrl(flags, eff_idx);

    // R2 and R3: a locked control port keeps its flags
    assert_locked_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && locked) |=> $stable(flags));

    assert_legacy_bit4_R5: assert property (@(posedge clk) disable iff (rst)
        (idx_wr && !locked && legacy_mode) |=> (flags.idx[IDX_W-1] == 1'b0));
endmodule

// File: rtl/regwin_bank.sv
module regwin_bank
    import regwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mce,
    output logic [BYTE_W-1:0] rdata
);
    logic [BYTE_W-1:0] regs [NUM_REGS];
    logic [BYTE_W-1:0] wr_mask;

    always_comb begin
        if (mce)
            wr_mask = '1;
        else if (is_cfg_reg(idx))
            wr_mask = CFG_FREE_MASK;
        else if (is_fmt_reg(idx))
            wr_mask = '0;
        else
            wr_mask = '1;
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)
                    regs[g] <= '0;
                else if (wr_en && idx == IDX_W'(g))
                    regs[g] <= (regs[g] & ~wr_mask) | (wdata & wr_mask);
            end
        end
    endgenerate

    assign rdata = regs[idx];

    assert_fmt_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mce && is_fmt_reg(idx)) |=> (regs[$past(idx)] == $past(rdata)));

    assert_cfg_partial_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !mce && is_cfg_reg(idx)) |=>
            (regs[CFG_IDX][BYTE_W-1:2] == $past(rdata[BYTE_W-1:2])));
endmodule

// File: rtl/regwin_dreq.sv
module regwin_dreq #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trd,
    input  logic [NUM_CH-1:0] req_in,
    input  logic [NUM_CH-1:0] irq,
    output logic [NUM_CH-1:0] req_out
);
    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign req_out[c] = req_in[c] & ~(trd & irq[c]);

            assert_gate_block_R9: assert property (@(posedge clk) disable iff (rst)
                (trd && irq[c]) |-> !req_out[c]);

            assert_gate_pass_R9: assert property (@(posedge clk) disable iff (rst)
                (!trd && req_in[c]) |-> req_out[c]);
        end
    endgenerate
endmodule

// File: rtl/regwin_top.sv
module regwin_top
    import regwin_pkg::*;
#(
    parameter int INIT_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_port,
    input  logic              host_wr,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              legacy_mode,
    input  logic              pwr_down,
    input  logic              play_drq_in,
    input  logic              capt_drq_in,
    input  logic              play_irq,
    input  logic              capt_irq,
    output logic              play_drq_out,
    output logic              capt_drq_out,
    output logic              dac_mute
);
    win_flags_t        flags;
    logic              init_busy;
    logic              locked;
    logic [IDX_W-1:0]  eff_idx;
    logic [BYTE_W-1:0] ctrl_rdata;
    logic [BYTE_W-1:0] bank_rdata;
    logic [1:0]        drq_out;

    regwin_ctrl #(.INIT_CYCLES(INIT_CYCLES)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .pwr_down   (pwr_down),
        .legacy_mode(legacy_mode),
        .idx_wr     (host_wr && host_port == PORT_CTRL),
        .wdata      (host_wdata),
        .flags      (flags),
        .init_busy  (init_busy),
        .locked     (locked),
        .eff_idx    (eff_idx),
        .ctrl_rdata (ctrl_rdata)
    );

    regwin_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .wr_en(host_wr && host_port == PORT_DATA && !init_busy),
        .idx  (eff_idx),
        .wdata(host_wdata),
        .mce  (flags.mce),
        .rdata(bank_rdata)
    );

    regwin_dreq #(.NUM_CH(2)) u_dreq (
        .clk    (clk),
        .rst    (rst),
        .trd    (flags.trd),
        .req_in ({capt_drq_in, play_drq_in}),
        .irq    ({capt_irq, play_irq}),
        .req_out(drq_out)
    );

    assign play_drq_out = drq_out[0];
    assign capt_drq_out = drq_out[1];
    assign dac_mute     = flags.mce;
    assign host_rdata   = (host_port == PORT_CTRL) ? ctrl_rdata : bank_rdata;

    assert_busy_read_R2: assert property (@(posedge clk) disable iff (rst)
        ((init_busy || pwr_down) && host_port == PORT_CTRL) |-> (host_rdata == BUSY_READ));

    assert_mute_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(dac_mute) |-> $past(host_wr && host_port == PORT_CTRL && host_wdata[6]));

    assert_bank_lockout_R2: assert property (@(posedge clk) disable iff (rst)
        (init_busy && host_port == PORT_DATA) |=> $stable(bank_rdata) || $changed(eff_idx));
endmodule

// File: tb/test_regwin_top.sv
module test_regwin_top;
    localparam int CLK_PERIOD = 10;
    localparam int INIT_N     = 16;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_port;
    logic       host_wr;
    logic [7:0] host_wdata;
    logic [7:0] host_rdata;
    logic       legacy_mode;
    logic       pwr_down;
    logic       play_drq_in, capt_drq_in, play_irq, capt_irq;
    logic       play_drq_out, capt_drq_out, dac_mute;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regwin_top #(.INIT_CYCLES(INIT_N)) i_regwin_top (
        .clk(clk), .rst(rst), .host_port(host_port), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .legacy_mode(legacy_mode), .pwr_down(pwr_down),
        .play_drq_in(play_drq_in), .capt_drq_in(capt_drq_in),
        .play_irq(play_irq), .capt_irq(capt_irq),
        .play_drq_out(play_drq_out), .capt_drq_out(capt_drq_out),
        .dac_mute(dac_mute)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37 + 11) & 255);
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic port, input logic [7:0] d);
        @(negedge clk);
        host_port = port; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic port, output logic [7:0] d);
        host_port = port;
        #1;
        d = host_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog all: act=hung exp=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        rst = 1'b1; host_port = 1'b0; host_wr = 1'b0; host_wdata = '0;
        legacy_mode = 1'b0; pwr_down = 1'b0;
        play_drq_in = 0; capt_drq_in = 0; play_irq = 0; capt_irq = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2: start-up lockout
        rd(1'b0, v); chk("R2 busy read", v, 8'h80);
        wr(1'b1, 8'h55);
        wr(1'b0, 8'h3F);
        rd(1'b0, v); chk("R2 busy read later", v, 8'h80);
        repeat (INIT_N + 2) @(negedge clk);
        rd(1'b0, v); chk("R2 idle value", v, 8'h40);
        chk("R8 mute after reset", {7'd0, dac_mute}, 8'h01);
        rd(1'b1, v); chk("R2 data write ignored", v, 8'h00);

        // R4: fill and read back all registers with mode change enabled
        for (int i = 0; i < 32; i++) begin
            wr(1'b0, 8'(8'h40 | i));
            wr(1'b1, pat(i));
        end
        for (int i = 0; i < 32; i++) begin
            wr(1'b0, 8'(8'h40 | i));
            rd(1'b1, v); chk("R4 readback", v, pat(i));
        end

        // R1: pointer and flag sweep
        for (int i = 0; i < 32; i++) begin
            for (int f = 0; f < 4; f++) begin
                wr(1'b0, 8'((f << 5) | i));
                rd(1'b0, v); chk("R1 ctrl readback", v, 8'((f << 5) | i));
                chk("R8 mute follows flag", {7'd0, dac_mute}, 8'(f >> 1));
            end
        end
        wr(1'b0, 8'hFF);
        rd(1'b0, v); chk("R1 bit7 read-only", v, 8'h7F);

        // R6 and R7: protection with mode change disabled
        wr(1'b0, 8'h08); wr(1'b1, ~pat(8));
        rd(1'b1, v); chk("R6 reg8 protected", v, pat(8));
        wr(1'b0, 8'h1C); wr(1'b1, ~pat(28));
        rd(1'b1, v); chk("R6 reg28 protected", v, pat(28));
        wr(1'b0, 8'h09); wr(1'b1, ~pat(9));
        rd(1'b1, v); chk("R7 reg9 partial", v, (pat(9) & 8'hFC) | (~pat(9) & 8'h03));
        wr(1'b0, 8'h0A); wr(1'b1, 8'hC3);
        rd(1'b1, v); chk("R6 unprotected reg10 writes", v, 8'hC3);
        wr(1'b0, 8'h48); wr(1'b1, 8'h99);
        rd(1'b1, v); chk("R6 reg8 writes with mce", v, 8'h99);
        chk("R8 mute on", {7'd0, dac_mute}, 8'h01);

        // R9: exhaustive request gating
        for (int t = 0; t < 2; t++) begin
            wr(1'b0, 8'(t << 5));
            for (int k = 0; k < 16; k++) begin
                play_drq_in = k[0]; capt_drq_in = k[1]; play_irq = k[2]; capt_irq = k[3];
                #1;
                chk("R9 play gate", {7'd0, play_drq_out}, {7'd0, k[0] & ~(t[0] & k[2])});
                chk("R9 capt gate", {7'd0, capt_drq_out}, {7'd0, k[1] & ~(t[0] & k[3])});
            end
        end

        // R5: legacy pointer restriction
        legacy_mode = 1'b1;
        wr(1'b0, 8'h5F);
        rd(1'b0, v); chk("R5 bit4 reads zero", v, 8'h4F);
        rd(1'b1, v); chk("R5 selects reg15", v, pat(15));
        legacy_mode = 1'b0;
        #1;
        rd(1'b0, v); chk("R5 bit4 stored zero", v, 8'h4F);

        // R3: power-down lock and restore
        wr(1'b0, 8'h2A);
        pwr_down = 1'b1;
        rd(1'b0, v); chk("R3 pd read", v, 8'h80);
        wr(1'b0, 8'h55);
        rd(1'b0, v); chk("R3 pd still busy", v, 8'h80);
        chk("R3 pd keeps mute off", {7'd0, dac_mute}, 8'h00);
        @(negedge clk);
        pwr_down = 1'b0;
        rd(1'b0, v); chk("R3 restored", v, 8'h2A);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule